// File: doc/BRIEF.md
# Signed Compare Condition-Field Generator

This block keeps a 32-bit condition register made of eight 4-bit fields and updates it from signed comparisons of 64-bit operands. Each field it writes holds three mutually exclusive flags, less-than, greater-than and equal, plus a copy of the sticky summary-overflow bit in its lowest position.

Two kinds of update feed the register. A result-recording update compares an ALU result with zero and always writes field 0. In 32-bit mode only the low 32 bits of the result count, taken as a signed word; in 64-bit mode the whole value counts. An explicit compare takes two operands and writes the field chosen by a 3-bit index. Its length select picks either the full 64-bit operands or the sign-extended low 32 bits of each. Both kinds of update may be requested in the same cycle.

Top module: `cmpf_unit`

## Requirements
- R1: Synchronous active-high reset clears the whole condition register to zero.
- R2: A written field is 4 bits, most significant first: less-than, greater-than, equal, summary-overflow. So less-than gives 4'b100s, greater-than gives 4'b010s and equal gives 4'b001s, where s is the summary-overflow input.
- R3: A result-recording update (rec_valid high) compares rec_value with zero as a signed number and writes field 0, which is cr_out[31:28]. With mode64 high, all 64 bits are compared.
- R4: With mode64 low, a result-recording update looks only at rec_value[31:0] as a signed 32-bit value. Bits 63:32 have no effect.
- R5: An explicit compare (cmp_valid high) with cmp_dword high compares cmp_a and cmp_b as full 64-bit two's-complement values.
- R6: An explicit compare with cmp_dword low compares the sign-extended low 32 bits of each operand. Bits 63:32 have no effect.
- R7: An explicit compare writes field cmp_slot. Field k occupies cr_out[31-4k:28-4k], so field 0 is the most significant nibble.
- R8: Every field not targeted by an update keeps its value.
- R9: With both rec_valid and cmp_valid low, the condition register holds its value.
- R10: When both updates happen in one cycle, both fields are written if cmp_slot is not 0. If cmp_slot is 0, the explicit compare result is written and the recorded result is dropped.
- R11: Bit 0 of every written field equals so_bit in the cycle of the update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode64 | input | 1 | 1: 64-bit mode for result recording, 0: 32-bit mode |
| so_bit | input | 1 | Current sticky summary-overflow bit |
| rec_valid | input | 1 | Result-recording update strobe |
| rec_value | input | 64 | ALU result compared with zero |
| cmp_valid | input | 1 | Explicit compare strobe |
| cmp_dword | input | 1 | 1: 64-bit operands, 0: sign-extended low words |
| cmp_slot | input | 3 | Destination field index of the explicit compare |
| cmp_a | input | 64 | First compare operand |
| cmp_b | input | 64 | Second compare operand |
| cr_out | output | 32 | Condition register |

## Verification
A result-recording update and an explicit compare can land in the same cycle, and they contend for the register only when the compare targets field 0. The bench raises both strobes in one cycle twice. In the first run the compare targets field 5, and both fields must be written while all others keep their values. In the second run the compare targets field 0 with a result that differs from the recorded one, and field 0 must hold the compare result. Each run is judged by comparing the whole register with a model built from the requirements.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;

    localparam int FIELD_W = 4;

    // One condition field, most significant member first.
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_field_t;

    function automatic cond_field_t make_field(input logic lt_i, input logic gt_i, input logic so_i);
        cond_field_t f;
        f.lt = lt_i;
        f.gt = gt_i;
        f.eq = ~(lt_i | gt_i);
        f.so = so_i;
        return f;
    endfunction

endpackage

// File: rtl/cmpf_operand_prep.sv
module cmpf_operand_prep #(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic [DATA_W-1:0] raw_i,
    input  logic              wide_i,
    output logic [DATA_W-1:0] opnd_o
);
    localparam int EXT_W = DATA_W - WORD_W;

    always_comb begin
        if (wide_i) opnd_o = raw_i;
        else        opnd_o = {{EXT_W{raw_i[WORD_W-1]}}, raw_i[WORD_W-1:0]};
    end
endmodule

// File: rtl/cmpf_signed_cmp.sv
module cmpf_signed_cmp
    import cmpf_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              so_i,
    output cond_field_t       field_o
);
    logic is_lt;
    logic is_gt;

    always_comb begin
        is_lt   = $signed(a_i) < $signed(b_i);
        is_gt   = $signed(a_i) > $signed(b_i);
        field_o = make_field(is_lt, is_gt, so_i);
    end
endmodule

// File: rtl/cmpf_cr_merge.sv
module cmpf_cr_merge
    import cmpf_pkg::*;
#(
    parameter int NUM_FIELDS = 8,
    parameter int IDX_W      = $clog2(NUM_FIELDS),
    parameter int CR_W       = FIELD_W * NUM_FIELDS
) (
    input  logic [CR_W-1:0]  cr_i,
    input  logic             rec_we_i,
    input  cond_field_t      rec_field_i,
    input  logic             cmp_we_i,
    input  logic [IDX_W-1:0] cmp_idx_i,
    input  cond_field_t      cmp_field_i,
    output logic [CR_W-1:0]  cr_o
);
    // Field k sits at bits counted from the most significant end.
    for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
        localparam int HI = CR_W - 1 - FIELD_W * k;
        logic cmp_hit;
        logic rec_hit;
        assign cmp_hit = cmp_we_i && (cmp_idx_i == IDX_W'(k));
        if (k == 0) begin : g_rec
            assign rec_hit = rec_we_i;
        end else begin : g_norec
            assign rec_hit = 1'b0;
        end
        always_comb begin
            if (cmp_hit)      cr_o[HI -: FIELD_W] = cmp_field_i;
            else if (rec_hit) cr_o[HI -: FIELD_W] = rec_field_i;
            else              cr_o[HI -: FIELD_W] = cr_i[HI -: FIELD_W];
        end
    end
endmodule

// File: rtl/cmpf_unit.sv
module cmpf_unit
    import cmpf_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int WORD_W     = 32,
    parameter int NUM_FIELDS = 8,
    localparam int IDX_W     = $clog2(NUM_FIELDS),
    localparam int CR_W      = FIELD_W * NUM_FIELDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode64,
    input  logic              so_bit,
    input  logic              rec_valid,
    input  logic [DATA_W-1:0] rec_value,
    input  logic              cmp_valid,
    input  logic              cmp_dword,
    input  logic [IDX_W-1:0]  cmp_slot,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    output logic [CR_W-1:0]   cr_out
);
    logic [DATA_W-1:0] rec_opnd;
    logic [DATA_W-1:0] a_opnd;
    logic [DATA_W-1:0] b_opnd;
    cond_field_t       rec_field;
    cond_field_t       cmp_field;
    logic [CR_W-1:0]   cr_q;
    logic [CR_W-1:0]   cr_next;

    cmpf_operand_prep #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_prep_rec (
        .raw_i(rec_value), .wide_i(mode64), .opnd_o(rec_opnd));
    cmpf_operand_prep #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_prep_a (
        .raw_i(cmp_a), .wide_i(cmp_dword), .opnd_o(a_opnd));
    cmpf_operand_prep #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_prep_b (
        .raw_i(cmp_b), .wide_i(cmp_dword), .opnd_o(b_opnd));

    cmpf_signed_cmp #(.DATA_W(DATA_W)) u_cmp_rec (
        .a_i(rec_opnd), .b_i('0), .so_i(so_bit), .field_o(rec_field));
    cmpf_signed_cmp #(.DATA_W(DATA_W)) u_cmp_reg (
        .a_i(a_opnd), .b_i(b_opnd), .so_i(so_bit), .field_o(cmp_field));

    cmpf_cr_merge #(.NUM_FIELDS(NUM_FIELDS), .IDX_W(IDX_W), .CR_W(CR_W)) u_merge (
        .cr_i(cr_q),
        .rec_we_i(rec_valid), .rec_field_i(rec_field),
        .cmp_we_i(cmp_valid), .cmp_idx_i(cmp_slot), .cmp_field_i(cmp_field),
        .cr_o(cr_next));

    always_ff @(posedge clk) begin
        if (rst)                          cr_q <= '0;
        else if (rec_valid || cmp_valid)  cr_q <= cr_next;
    end

    assign cr_out = cr_q;
endmodule

// File: rtl/cmpf_unit_chk.sv
module cmpf_unit_chk #(
    parameter int DATA_W     = 64,
    parameter int NUM_FIELDS = 8,
    parameter int IDX_W      = 3,
    parameter int CR_W       = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mode64,
    input logic              so_bit,
    input logic              rec_valid,
    input logic [DATA_W-1:0] rec_value,
    input logic              cmp_valid,
    input logic [IDX_W-1:0]  cmp_slot,
    input logic [CR_W-1:0]   cr_out
);
    function automatic logic [3:0] nib(input logic [CR_W-1:0] cr, input logic [IDX_W-1:0] idx);
        return cr[CR_W-1-4*int'(idx) -: 4];
    endfunction

    function automatic logic [CR_W-1:0] others_mask(input logic [IDX_W-1:0] idx);
        logic [CR_W-1:0] m;
        m = '1;
        m[CR_W-1-4*int'(idx) -: 4] = 4'h0;
        return m;
    endfunction

    logic rec_alone;
    assign rec_alone = rec_valid && !(cmp_valid && cmp_slot == '0);

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> cr_out == '0);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rec_valid && !cmp_valid) |=> $stable(cr_out));

    // R8
    cmp_others_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && !rec_valid) |=>
        ((cr_out & others_mask($past(cmp_slot))) == ($past(cr_out) & others_mask($past(cmp_slot)))));

    // R2
    cmp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |=> $countones(nib(cr_out, $past(cmp_slot)) >> 1) == 1);

    // R11
    cmp_so_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |=> nib(cr_out, $past(cmp_slot))[0] == $past(so_bit));

    // R3
    rec_sign64_chk: assert property (@(posedge clk) disable iff (rst)
        (rec_alone && mode64) |=> cr_out[CR_W-1] == $past(rec_value[DATA_W-1]));

    // R4
    rec_sign32_chk: assert property (@(posedge clk) disable iff (rst)
        (rec_alone && !mode64) |=> cr_out[CR_W-1] == $past(rec_value[31]));
endmodule

bind cmpf_unit cmpf_unit_chk #(
    .DATA_W(DATA_W), .NUM_FIELDS(NUM_FIELDS), .IDX_W(IDX_W), .CR_W(CR_W)
) u_chk (
    .clk(clk), .rst(rst), .mode64(mode64), .so_bit(so_bit),
    .rec_valid(rec_valid), .rec_value(rec_value),
    .cmp_valid(cmp_valid), .cmp_slot(cmp_slot), .cr_out(cr_out)
);

// File: tb/cmpf_unit_tb.sv
module cmpf_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        mode64;
    logic        so_bit;
    logic        rec_valid;
    logic [63:0] rec_value;
    logic        cmp_valid;
    logic        cmp_dword;
    logic [2:0]  cmp_slot;
    logic [63:0] cmp_a;
    logic [63:0] cmp_b;
    logic [31:0] cr_out;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_cr;
    bit done = 0;

    always #5 clk = ~clk;

    cmpf_unit u_dut (
        .clk(clk), .rst(rst), .mode64(mode64), .so_bit(so_bit),
        .rec_valid(rec_valid), .rec_value(rec_value),
        .cmp_valid(cmp_valid), .cmp_dword(cmp_dword), .cmp_slot(cmp_slot),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cr_out(cr_out));

    localparam logic [3:0] LT = 4'b1000, GT = 4'b0100, EQ = 4'b0010;

    function automatic logic [31:0] put(input logic [31:0] cr, input int k, input logic [3:0] f);
        logic [31:0] r;
        r = cr;
        r[31-4*k -: 4] = f;
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] exp);
        checks++;
        if (cr_out !== exp) begin
            errors++;
            $display("FAIL %s: cr_out=%h expected=%h", req, cr_out, exp);
        end
    endtask

    task automatic idle_inputs();
        rec_valid = 0; cmp_valid = 0;
    endtask

    // drive at negedge, one posedge, check at following negedge
    task automatic step(input logic rv, input logic [63:0] rval, input logic m64,
                        input logic cv, input logic dw, input logic [2:0] sl,
                        input logic [63:0] a, input logic [63:0] b, input logic so);
        rec_valid = rv; rec_value = rval; mode64 = m64;
        cmp_valid = cv; cmp_dword = dw; cmp_slot = sl; cmp_a = a; cmp_b = b; so_bit = so;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_reset();
        rst = 1; idle_inputs(); mode64 = 1; so_bit = 0;
        rec_value = '1; cmp_dword = 0; cmp_slot = 0; cmp_a = 0; cmp_b = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        exp_cr = '0;
        check("R1 reset", exp_cr);
    endtask

    task automatic t_record64();
        step(1, 64'hFFFF_FFFF_FFFF_FFFE, 1, 0, 0, 0, 0, 0, 0);
        exp_cr = put(exp_cr, 0, LT); check("R3 rec64 negative", exp_cr);
        step(1, 64'h0000_0001_0000_0000, 1, 0, 0, 0, 0, 0, 1);
        exp_cr = put(exp_cr, 0, GT | 4'b1); check("R3 R11 rec64 positive so", exp_cr);
        step(1, 64'h0, 1, 0, 0, 0, 0, 0, 0);
        exp_cr = put(exp_cr, 0, EQ); check("R2 rec64 zero", exp_cr);
    endtask

    task automatic t_record32();
        step(1, 64'h0000_0001_0000_0000, 0, 0, 0, 0, 0, 0, 0);
        exp_cr = put(exp_cr, 0, EQ); check("R4 rec32 upper ignored", exp_cr);
        step(1, 64'h0000_0000_8000_0000, 0, 0, 0, 0, 0, 0, 0);
        exp_cr = put(exp_cr, 0, LT); check("R4 rec32 word negative", exp_cr);
        step(1, 64'hFFFF_FFFF_0000_0007, 0, 0, 0, 0, 0, 0, 1);
        exp_cr = put(exp_cr, 0, GT | 4'b1); check("R4 rec32 word positive", exp_cr);
    endtask

    task automatic t_cmp64();
        step(0, 0, 1, 1, 1, 3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0);
        exp_cr = put(exp_cr, 2, LT); check("R5 dword -1 vs 1", exp_cr);
        step(0, 0, 1, 1, 1, 3'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1);
        exp_cr = put(exp_cr, 3, GT | 4'b1); check("R5 dword max vs min", exp_cr);
        step(0, 0, 1, 1, 1, 3'd4, 64'h0000_0000_FFFF_FFFF, 64'h0, 0);
        exp_cr = put(exp_cr, 4, GT); check("R5 dword low-word bit", exp_cr);
    endtask

    task automatic t_cmp32();
        step(0, 0, 1, 1, 0, 3'd4, 64'h0000_0000_FFFF_FFFF, 64'h0, 0);
        exp_cr = put(exp_cr, 4, LT); check("R6 word sign-extend", exp_cr);
        step(0, 0, 1, 1, 0, 3'd6, 64'hAAAA_0000_0000_0005, 64'h5555_0000_0000_0005, 1);
        exp_cr = put(exp_cr, 6, EQ | 4'b1); check("R6 word upper ignored", exp_cr);
    endtask

    task automatic t_slots();
        for (int k = 0; k < 8; k++) begin
            logic [3:0] f;
            f = (k % 3 == 0) ? LT : (k % 3 == 1) ? GT : EQ;
            f[0] = k[0];
            step(0, 0, 1, 1, 1, 3'(k),
                 (k % 3 == 0) ? 64'd1 : (k % 3 == 1) ? 64'd9 : 64'd5, 64'd5, k[0]);
            exp_cr = put(exp_cr, k, f);
            check($sformatf("R7 R8 slot %0d", k), exp_cr);
        end
    endtask

    task automatic t_idle();
        step(0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 1, 3'd1, 64'h5, 64'h0, 1);
        check("R9 idle hold", exp_cr);
        step(0, 64'h0, 0, 0, 0, 3'd0, 64'h0, 64'h9, 0);
        check("R9 idle hold again", exp_cr);
    endtask

    task automatic t_same_cycle();
        step(1, 64'hFFFF_FFFF_FFFF_FF00, 1, 1, 1, 3'd5, 64'd2, 64'd2, 0);
        exp_cr = put(exp_cr, 0, LT);
        exp_cr = put(exp_cr, 5, EQ);
        check("R10 both fields written", exp_cr);
        step(1, 64'd0, 1, 1, 1, 3'd0, 64'd7, 64'd3, 1);
        exp_cr = put(exp_cr, 0, GT | 4'b1);
        check("R10 explicit wins field 0", exp_cr);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_record64();
        t_record32();
        t_cmp64();
        t_cmp32();
        t_slots();
        t_idle();
        t_same_cycle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule